// File: doc/BRIEF.md
# Branch Confidence Estimator

This block keeps one small saturating counter per table slot and tells a control-independence core whether the current direction prediction for a branch can be trusted. A low-confidence answer marks the branch as a candidate for protection. The direction predictor and the protection policy sit outside this block.

The front end presents a branch address on the lookup port. The block forms a table index by combining that address with its internal global outcome history, in the usual pattern-history-table style. One cycle later it returns the stored counter value, a high-confidence flag and the history it used. The flag is set only when the counter sits at its maximum. When the branch resolves, the back end presents the same address and the history snapshot taken at lookup time. It also presents the actual direction and whether the prediction was right. A right prediction moves the counter up by one, and the counter stops at its maximum. A wrong prediction clears the counter to zero. The taken bit is shifted into the global history.

After reset, an initialisation sweep writes the maximum value into every slot, one slot per clock. This keeps the table mappable to on-chip RAM. A ready flag marks the end of the sweep.

Top module: `conf_estimator`

## Requirements
- R1: After synchronous reset, `ready_o` is 0. It rises exactly ENTRIES (256) clocks after reset is released and then stays 1. While `ready_o` is 0, a lookup request produces no `lk_valid_o`.
- R2: Once `ready_o` is 1, a slot that has never been updated reads level 15 with `lk_high_o` = 1.
- R3: The table index is `pc[9:2] XOR history`, where history is the 8-bit global history.
- R4: A lookup request in cycle t gives `lk_valid_o` = 1 in cycle t+1, together with the level and `lk_hist_o`. `lk_high_o` is 1 exactly when the level is 15.
- R5: An accepted update with `upd_correct_i` = 1 adds one to the addressed counter. At 15 the counter stays at 15.
- R6: An accepted update with `upd_correct_i` = 0 sets the addressed counter to 0.
- R7: When a lookup and an update address the same slot in the same cycle, the lookup returns the value held before that update.
- R8: `ghr_o` resets to 0. On each accepted update it shifts left by one and takes `upd_taken_i` into bit 0.
- R9: While `ready_o` is 0, updates are ignored. The table and `ghr_o` are unchanged.
- R10: A lookup indexes with the internal history `ghr_o`. An update indexes with the supplied `upd_hist_i`, not with `ghr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Branch address to look up |
| lk_valid_o | output | 1 | Lookup result valid (one cycle after request) |
| lk_high_o | output | 1 | High confidence (counter at maximum) |
| lk_level_o | output | 4 | Counter value read |
| lk_hist_o | output | 8 | History used to form the lookup index |
| upd_valid_i | input | 1 | Resolved-branch update |
| upd_pc_i | input | 32 | Branch address of the resolved branch |
| upd_hist_i | input | 8 | History snapshot taken at lookup |
| upd_taken_i | input | 1 | Actual branch direction |
| upd_correct_i | input | 1 | 1 = prediction was right, 0 = mispredicted |
| ready_o | output | 1 | Initialisation sweep finished |
| ghr_o | output | 8 | Current global outcome history |

## Verification
A corrupted counter shows up on the next lookup of that slot as a wrong level, and often as a wrong confidence flag. The bench therefore follows every update with a read-back through the lookup port, and the error appears within two clocks of its cause. A wrong history value shows up at once on `ghr_o` and `lk_hist_o`. It also moves later lookups to the wrong slot, so a per-slot reference model catches it in a long mixed sequence. Sweep faults appear as a wrong count to `ready_o`, or as a slot that does not read 15 after start-up.

// File: rtl/conf_pkg.sv
package conf_pkg;
  // Next counter value after a resolved branch
  function automatic logic [3:0] cnt_next(input logic [3:0] cur, input logic ok);
    if (!ok)
      return 4'd0;
    else if (cur == 4'hF)
      return cur;
    else
      return cur + 4'd1;
  endfunction
endpackage

// File: rtl/conf_ghr.sv
module conf_ghr #(
  parameter int GHR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [GHR_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)
      hist <= '0;
    else if (shift_en)
      hist <= {hist[GHR_W-2:0], bit_in};
  end
endmodule

// File: rtl/conf_init_sweep.sv
module conf_init_sweep #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] addr,
  output logic             ready
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      busy  <= 1'b1;
      ready <= 1'b0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/conf_table.sv
module conf_table #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_level,
  output logic             rd_max,
  input  logic [IDX_W-1:0] rmw_addr,
  output logic [CNT_W-1:0] rmw_old,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mem [ENTRIES];

  // read-first: registered read sees contents before this edge's write
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
    if (rd_en) begin
      rd_level <= mem[rd_addr];
      rd_max   <= (mem[rd_addr] == MAXV);
    end
  end

  assign rmw_old = mem[rmw_addr];
endmodule

// File: rtl/conf_estimator.sv
module conf_estimator #(
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int IDX_W    = 8,
  parameter int GHR_W    = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             lk_valid_o,
  output logic             lk_high_o,
  output logic [CNT_W-1:0] lk_level_o,
  output logic [GHR_W-1:0] lk_hist_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [GHR_W-1:0] upd_hist_i,
  input  logic             upd_taken_i,
  input  logic             upd_correct_i,
  output logic             ready_o,
  output logic [GHR_W-1:0] ghr_o
);
  import conf_pkg::*;

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic             sweep_busy;
  logic [IDX_W-1:0] sweep_addr;
  logic             ready;
  logic [GHR_W-1:0] ghr;
  logic             upd_acc;
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [CNT_W-1:0] upd_old;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] rd_level;
  logic             rd_max;
  logic             valid_q;
  logic [GHR_W-1:0] hist_q;

  function automatic logic [IDX_W-1:0] make_idx(input logic [PC_W-1:0] pc,
                                                input logic [GHR_W-1:0] h);
    logic [IDX_W-1:0] hx;
    hx = '0;
    hx[GHR_W-1:0] = h;
    return pc[PC_SHIFT +: IDX_W] ^ hx;
  endfunction

  conf_init_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst), .busy(sweep_busy), .addr(sweep_addr), .ready(ready)
  );

  assign upd_acc = upd_valid_i & ready;

  conf_ghr #(.GHR_W(GHR_W)) u_ghr (
    .clk(clk), .rst(rst), .shift_en(upd_acc), .bit_in(upd_taken_i), .hist(ghr)
  );

  assign lk_idx  = make_idx(lk_pc_i, ghr);
  assign upd_idx = make_idx(upd_pc_i, upd_hist_i);

  always_comb begin
    if (sweep_busy) begin
      wr_en   = 1'b1;
      wr_addr = sweep_addr;
      wr_data = MAXV;
    end else begin
      wr_en   = upd_acc;
      wr_addr = upd_idx;
      wr_data = cnt_next(upd_old, upd_correct_i);
    end
  end

  conf_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk),
    .rd_en(lk_req_i & ready), .rd_addr(lk_idx),
    .rd_level(rd_level), .rd_max(rd_max),
    .rmw_addr(upd_idx), .rmw_old(upd_old),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      hist_q  <= '0;
    end else begin
      valid_q <= lk_req_i & ready;
      if (lk_req_i & ready)
        hist_q <= ghr;
    end
  end

  assign lk_valid_o = valid_q;
  assign lk_high_o  = rd_max;
  assign lk_level_o = rd_level;
  assign lk_hist_o  = hist_q;
  assign ready_o    = ready;
  assign ghr_o      = ghr;
endmodule

// File: rtl/conf_estimator_chk.sv
module conf_estimator_chk #(
  parameter int GHR_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_req_i,
  input logic             lk_valid_o,
  input logic             lk_high_o,
  input logic [CNT_W-1:0] lk_level_o,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic             ready_o,
  input logic [GHR_W-1:0] ghr_o
);
  // R1: ready never drops outside reset
  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  // R1: no result without readiness at request time
  p_no_valid_early_r1: assert property (@(posedge clk) disable iff (rst)
    lk_valid_o |-> $past(ready_o) && $past(lk_req_i));

  // R4: flag set only at maximum level
  p_high_at_max_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_o && lk_high_o) |-> (lk_level_o == {CNT_W{1'b1}}));

  // R4: maximum level always flagged
  p_max_is_high_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_o && lk_level_o == {CNT_W{1'b1}}) |-> lk_high_o);

  // R8: accepted update shifts the taken bit in
  p_ghr_shift_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && upd_valid_i) |=> ghr_o == {$past(ghr_o[GHR_W-2:0]), $past(upd_taken_i)});

  // R9: history frozen without an accepted update
  p_ghr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && upd_valid_i) |=> $stable(ghr_o));
endmodule

bind conf_estimator conf_estimator_chk #(.GHR_W(GHR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req_i(lk_req_i), .lk_valid_o(lk_valid_o),
  .lk_high_o(lk_high_o), .lk_level_o(lk_level_o), .upd_valid_i(upd_valid_i),
  .upd_taken_i(upd_taken_i), .ready_o(ready_o), .ghr_o(ghr_o)
);

// File: tb/conf_estimator_bench.sv
module conf_estimator_bench;
  localparam int N = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req_i;
  logic [31:0] lk_pc_i;
  logic        lk_valid_o, lk_high_o;
  logic [3:0]  lk_level_o;
  logic [7:0]  lk_hist_o;
  logic        upd_valid_i;
  logic [31:0] upd_pc_i;
  logic [7:0]  upd_hist_i;
  logic        upd_taken_i, upd_correct_i;
  logic        ready_o;
  logic [7:0]  ghr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int ref_tab [N];
  logic [7:0] m_ghr;

  always #2 clk = ~clk;

  conf_estimator u_conf_estimator (
    .clk(clk), .rst(rst),
    .lk_req_i(lk_req_i), .lk_pc_i(lk_pc_i),
    .lk_valid_o(lk_valid_o), .lk_high_o(lk_high_o),
    .lk_level_o(lk_level_o), .lk_hist_o(lk_hist_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_hist_i(upd_hist_i),
    .upd_taken_i(upd_taken_i), .upd_correct_i(upd_correct_i),
    .ready_o(ready_o), .ghr_o(ghr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [31:0] pc, input logic [7:0] h);
    return int'(pc[9:2] ^ h);
  endfunction

  function automatic logic [31:0] pc_for(input int idx, input logic [7:0] h);
    logic [31:0] p;
    p = '0;
    p[9:2] = 8'(idx) ^ h;
    return p;
  endfunction

  // lookup, then check level, flag, valid and history against the model
  task automatic look(input logic [31:0] pc, input string req);
    int e;
    e = ref_tab[idx_of(pc, m_ghr)];
    lk_req_i = 1'b1; lk_pc_i = pc;
    @(negedge clk);
    lk_req_i = 1'b0;
    chk(req, int'(lk_valid_o), 1);
    chk(req, int'(lk_level_o), e);
    chk(req, int'(lk_high_o), (e == 15) ? 1 : 0);
    chk(req, int'(lk_hist_o), int'(m_ghr));
  endtask

  task automatic upd(input logic [31:0] pc, input logic [7:0] h,
                     input bit tk, input bit ok);
    int i;
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_hist_i = h;
    upd_taken_i = tk; upd_correct_i = ok;
    @(negedge clk);
    upd_valid_i = 1'b0;
    i = idx_of(pc, h);
    ref_tab[i] = ok ? ((ref_tab[i] < 15) ? ref_tab[i] + 1 : 15) : 0;
    m_ghr = {m_ghr[6:0], tk};
    chk("R8", int'(ghr_o), int'(m_ghr));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] lfsr;
    rst = 1'b1; lk_req_i = 0; lk_pc_i = '0; upd_valid_i = 0; upd_pc_i = '0;
    upd_hist_i = '0; upd_taken_i = 0; upd_correct_i = 0;
    m_ghr = '0;
    for (int i = 0; i < N; i++) ref_tab[i] = 15;
    repeat (3) @(negedge clk);
    chk("R1", int'(ready_o), 0);
    chk("R8", int'(ghr_o), 0);
    chk("R1", int'(lk_valid_o), 0);
    rst = 1'b0;

    // R1/R9: request and mispredict-update during the sweep
    lk_req_i = 1'b1; lk_pc_i = 32'h14;
    upd_valid_i = 1'b1; upd_pc_i = 32'h14; upd_hist_i = '0;
    upd_taken_i = 1'b1; upd_correct_i = 1'b0;
    n = 0;
    while (!ready_o && n < 1000) begin
      @(negedge clk);
      n++;
      if (lk_valid_o) chk("R1", int'(lk_valid_o), 0);
    end
    lk_req_i = 0; upd_valid_i = 0;
    chk("R1", n, N);
    chk("R9", int'(ghr_o), 0);
    repeat (2) @(negedge clk);
    chk("R1", int'(ready_o), 1);
    chk("R1", int'(lk_valid_o), 0);

    // R2/R3: every slot reads 15 and high; 0x14 untouched (R9)
    for (int i = 0; i < N; i++) look(pc_for(i, m_ghr), "R2");

    // R6: clear a few slots
    for (int i = 0; i < 8; i++) begin
      upd(pc_for(i * 31, 8'h00), 8'h00, i[0], 1'b0);
      look(pc_for(i * 31, m_ghr), "R6");
    end

    // R5/R4: climb from 0 to 15 and saturate
    for (int k = 0; k < 18; k++) begin
      upd(pc_for(0, 8'h00), 8'h00, 1'b0, 1'b1);
      look(pc_for(0, m_ghr), "R5");
    end

    // R7: same slot looked up and updated in one cycle
    upd(pc_for(40, 8'h00), 8'h00, 1'b1, 1'b0);
    upd(pc_for(40, 8'h00), 8'h00, 1'b0, 1'b1);
    begin
      int e_old;
      e_old = ref_tab[40];
      lk_req_i = 1'b1; lk_pc_i = pc_for(40, m_ghr);
      upd_valid_i = 1'b1; upd_pc_i = pc_for(40, m_ghr); upd_hist_i = m_ghr;
      upd_taken_i = 1'b1; upd_correct_i = 1'b0;
      @(negedge clk);
      lk_req_i = 0; upd_valid_i = 0;
      chk("R7", int'(lk_level_o), e_old);
      ref_tab[40] = 0;
      m_ghr = {m_ghr[6:0], 1'b1};
      look(pc_for(40, m_ghr), "R7");
    end

    // R10: update indexes with supplied history, not ghr_o
    begin
      logic [7:0] hs;
      hs = m_ghr ^ 8'h5A;
      upd(pc_for(100, hs), hs, 1'b0, 1'b0);
      chk("R10", ref_tab[100], 0);
      look(pc_for(100, m_ghr), "R10");
      look(pc_for(100 ^ 8'h5A, m_ghr), "R10");
    end

    // R3/R5/R6/R8: mixed pseudo-random traffic against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0])
        upd({22'd0, lfsr[11:4], 2'b00}, lfsr[15:8], lfsr[2], lfsr[3] | lfsr[5] | lfsr[6]);
      else
        look({22'd0, lfsr[12:5], 2'b00}, "R3");
    end

    finish_run();
  end
endmodule